// File: doc/BRIEF.md
# Instruction Prefix and Field Parser

This block is the byte-serial front end of an instruction decoder. It takes one instruction byte per cycle under a valid/ready handshake. Any mix of segment-override, address-size, operand-size and repeat prefixes is gathered first, in any order, with the last override of each class winning. The first byte that is not a prefix is the opcode. A small opcode subset then tells the parser which of the optional ModRM, SIB, displacement and immediate fields follow, and how many bytes each one takes.

When the last byte of an instruction is accepted, the parser publishes a decoded record with a one-cycle `o_done` pulse and goes back to gathering prefixes. The record holds the winning segment override, the effective operand and address sizes, the repeat kind, the opcode, an escape flag, an unknown-opcode flag, and each optional field's presence, length and value. The record stays unchanged until the next pulse. The default code-segment size is set by `CODE32`; with the default of 0, both sizes start at 16 bits.

The control is a state machine with six states. `ST_PFX` gathers prefixes and takes the opcode. `ST_ESC` takes the second byte after the escape byte. `ST_MODRM`, `ST_SIB`, `ST_DISP` and `ST_IMM` take the fields. The transitions are:
- `ST_PFX` goes to `ST_ESC` on 0Fh, to `ST_MODRM` for an opcode that takes ModRM, and to `ST_IMM` for an opcode that takes only an immediate.
- `ST_MODRM` goes to `ST_SIB`, `ST_DISP` or `ST_IMM`.
- `ST_SIB` goes to `ST_DISP` or `ST_IMM`.
- `ST_DISP` goes to `ST_IMM`.
- Every finished instruction, including the prefix-overflow error, returns to `ST_PFX`.

Top module: `ipfx_parser`

## Requirements
- R1: While `rst_n` is low, `o_ready` and `o_done` are 0 and every record output is 0. From the first cycle after reset, `o_ready` is 1.
- R2: The segment overrides are coded on `o_seg` as: 26h=1 (ES), 2Eh=2 (CS), 36h=3 (SS), 3Eh=4 (DS), 64h=5 (FS), 65h=6 (GS). With no override, `o_seg` is 0. If several overrides appear, the last one wins.
- R3: Byte 66h sets `o_osz32` and byte 67h sets `o_asz32` to the size opposite the code-segment default. With `CODE32`=0 each flag is 0 without its prefix and 1 with it, whatever the order of the prefixes.
- R4: F3h gives `o_rep`=1 and F2h gives `o_rep`=2. Without either, `o_rep` is 0. If both appear, the last one wins.
- R5: A prefix byte that arrives after 14 prefixes already gathered ends the instruction. That instruction is reported with `o_err`=1, `o_opc`=0, no ModRM and zero field lengths, and the next byte starts a new instruction.
- R6: Opcodes that take a ModRM byte are: 00h-3Fh with low three bits 0-3, 88h-8Bh, 80h, 81h, 83h, C6h and C7h. Opcodes with no fields are 90h-97h and C3h.
- R7: With 16-bit addressing (mod in bits 7:6, rm in bits 2:0 of ModRM), the displacement length is:
  - mod=01: 1 byte;
  - mod=10: 2 bytes;
  - mod=00 with rm=110: 2 bytes;
  - otherwise (including mod=11): none.
- R8: With 32-bit addressing, a SIB byte follows when rm=100 and mod≠11. The displacement length is:
  - mod=01: 1 byte;
  - mod=10: 4 bytes;
  - mod=00 with rm=101: 4 bytes;
  - mod=00 with a SIB byte whose base field (bits 2:0) is 101: 4 bytes.
- R9: An 8-bit immediate (1 byte) follows:
  - opcodes whose low three bits are 4 within 00h-3Fh;
  - 80h, 83h, B0h-B7h, C6h and EBh.
  A full-size immediate (2 bytes, or 4 bytes when `o_osz32`=1) follows:
  - opcodes whose low three bits are 5 within 00h-3Fh;
  - 81h, B8h-BFh, C7h, E8h and E9h.
- R10: Displacement and immediate bytes are packed little-endian into `o_disp` and `o_imm`, and the unused upper bytes are 0.
- R11: Byte 0Fh in the opcode position sets `o_esc`. The next byte becomes `o_opc`, and no further field is expected.
- R12: `o_done` is high for exactly the one cycle after the last byte of an instruction is accepted. Cycles with `i_valid` low make no progress, and the record holds its value until the next `o_done`.
- R13: Any other opcode (not a prefix, not 0Fh, not in R6 or R9) sets `o_unk` and is a one-byte instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Input byte is valid |
| i_byte | input | 8 | Instruction byte |
| o_ready | output | 1 | Parser takes a byte this cycle |
| o_done | output | 1 | Record published (one-cycle pulse) |
| o_err | output | 1 | Prefix-count overflow |
| o_seg | output | 3 | Winning segment override code |
| o_osz32 | output | 1 | Effective operand size is 32 bits |
| o_asz32 | output | 1 | Effective address size is 32 bits |
| o_rep | output | 2 | Repeat kind |
| o_esc | output | 1 | Two-byte escape seen |
| o_unk | output | 1 | Opcode outside supported subset |
| o_opc | output | 8 | Opcode byte |
| o_has_modrm | output | 1 | ModRM present |
| o_modrm | output | 8 | ModRM value |
| o_has_sib | output | 1 | SIB present |
| o_sib | output | 8 | SIB value |
| o_disp_len | output | 3 | Displacement length in bytes |
| o_disp | output | 32 | Displacement value |
| o_imm_len | output | 3 | Immediate length in bytes |
| o_imm | output | 32 | Immediate value |

## Verification
The assertions assume two things: after reset, bytes arrive only through the handshake, and `rst_n` stays steady during a run, so every published record comes from one whole instruction. The stimulus keeps to this. It raises `i_valid` only after reset, drives one byte per accepted cycle with random idle gaps in between, and feeds a single continuous stream. That stream mixes directed sequences (override order, SIB base cases, overflow at the fifteenth prefix) with weighted random prefixes, supported opcodes and arbitrary bytes. Records that the stream's tail leaves unfinished are never expected.

// File: rtl/ipfx_pkg.sv
package ipfx_pkg;

    typedef enum logic [2:0] {
        SEG_NONE = 3'd0,
        SEG_ES   = 3'd1,
        SEG_CS   = 3'd2,
        SEG_SS   = 3'd3,
        SEG_DS   = 3'd4,
        SEG_FS   = 3'd5,
        SEG_GS   = 3'd6
    } seg_e;

    typedef enum logic [1:0] {
        REP_NONE  = 2'd0,
        REP_EQ    = 2'd1,
        REP_NE    = 2'd2
    } rep_e;

    typedef enum logic [1:0] {
        IMM_NONE = 2'd0,
        IMM_BYTE = 2'd1,
        IMM_FULL = 2'd2
    } immk_e;

    typedef enum logic [1:0] {
        PC_SEG = 2'd0,
        PC_ASZ = 2'd1,
        PC_OSZ = 2'd2,
        PC_REP = 2'd3
    } pcls_e;

    typedef enum logic [2:0] {
        ST_PFX   = 3'd0,
        ST_ESC   = 3'd1,
        ST_MODRM = 3'd2,
        ST_SIB   = 3'd3,
        ST_DISP  = 3'd4,
        ST_IMM   = 3'd5
    } st_e;

    localparam int BYTE_W   = 8;
    localparam int FIELD_BY = 4;
    localparam int FIELD_W  = BYTE_W * FIELD_BY;
    localparam int LEN_W    = $clog2(FIELD_BY + 1);

    localparam logic [BYTE_W-1:0] ESC_BYTE = 8'h0F;

    typedef struct packed {
        logic                err;
        seg_e                seg;
        logic                osz;
        logic                asz;
        rep_e                rep;
        logic                esc;
        logic                unk;
        logic [BYTE_W-1:0]   opc;
        logic                has_m;
        logic [BYTE_W-1:0]   modrm;
        logic                has_s;
        logic [BYTE_W-1:0]   sib;
        logic [LEN_W-1:0]    dlen;
        logic [FIELD_W-1:0]  disp;
        logic [LEN_W-1:0]    ilen;
        logic [FIELD_W-1:0]  imm;
    } rec_t;

endpackage

// File: rtl/ipfx_pfx_dec.sv
module ipfx_pfx_dec
    import ipfx_pkg::*;
(
    input  logic [BYTE_W-1:0] i_b,
    output logic              o_is,
    output pcls_e             o_cls,
    output seg_e              o_seg,
    output rep_e              o_rep
);
    always_comb begin
        o_is  = 1'b1;
        o_cls = PC_SEG;
        o_seg = SEG_NONE;
        o_rep = REP_NONE;
        unique case (i_b)
            8'h26:   o_seg = SEG_ES;
            8'h2E:   o_seg = SEG_CS;
            8'h36:   o_seg = SEG_SS;
            8'h3E:   o_seg = SEG_DS;
            8'h64:   o_seg = SEG_FS;
            8'h65:   o_seg = SEG_GS;
            8'h66:   o_cls = PC_OSZ;
            8'h67:   o_cls = PC_ASZ;
            8'hF2: begin
                o_cls = PC_REP;
                o_rep = REP_NE;
            end
            8'hF3: begin
                o_cls = PC_REP;
                o_rep = REP_EQ;
            end
            default: o_is = 1'b0;
        endcase
    end
endmodule

// File: rtl/ipfx_op_dec.sv
module ipfx_op_dec
    import ipfx_pkg::*;
(
    input  logic [BYTE_W-1:0] i_b,
    output logic              o_has_m,
    output immk_e             o_imm,
    output logic              o_unk
);
    always_comb begin
        o_has_m = 1'b0;
        o_imm   = IMM_NONE;
        o_unk   = 1'b0;
        if (i_b[7:6] == 2'b00) begin
            if (i_b[2:0] <= 3'd3) begin
                o_has_m = 1'b1;
            end else if (i_b[2:0] == 3'd4) begin
                o_imm = IMM_BYTE;
            end else if (i_b[2:0] == 3'd5) begin
                o_imm = IMM_FULL;
            end else begin
                o_unk = 1'b1;
            end
        end else begin
            casez (i_b)
                8'b1000_10??: o_has_m = 1'b1;
                8'h80, 8'h83: begin
                    o_has_m = 1'b1;
                    o_imm   = IMM_BYTE;
                end
                8'h81: begin
                    o_has_m = 1'b1;
                    o_imm   = IMM_FULL;
                end
                8'b1001_0???: o_imm = IMM_NONE;
                8'b1011_0???: o_imm = IMM_BYTE;
                8'b1011_1???: o_imm = IMM_FULL;
                8'hC3:        o_imm = IMM_NONE;
                8'hC6: begin
                    o_has_m = 1'b1;
                    o_imm   = IMM_BYTE;
                end
                8'hC7: begin
                    o_has_m = 1'b1;
                    o_imm   = IMM_FULL;
                end
                8'hE8, 8'hE9: o_imm = IMM_FULL;
                8'hEB:        o_imm = IMM_BYTE;
                default:      o_unk = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ipfx_ea_len.sv
module ipfx_ea_len
    import ipfx_pkg::*;
(
    input  logic [1:0]       i_mod,
    input  logic [2:0]       i_rm,
    input  logic             i_asz32,
    output logic             o_sib,
    output logic [LEN_W-1:0] o_dlen
);
    always_comb begin
        o_sib  = 1'b0;
        o_dlen = '0;
        if (i_mod != 2'd3) begin
            if (i_asz32) begin
                o_sib = (i_rm == 3'd4);
                unique case (i_mod)
                    2'd1:    o_dlen = LEN_W'(1);
                    2'd2:    o_dlen = LEN_W'(4);
                    default: o_dlen = (i_rm == 3'd5) ? LEN_W'(4) : '0;
                endcase
            end else begin
                unique case (i_mod)
                    2'd1:    o_dlen = LEN_W'(1);
                    2'd2:    o_dlen = LEN_W'(2);
                    default: o_dlen = (i_rm == 3'd6) ? LEN_W'(2) : '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/ipfx_parser.sv
module ipfx_parser
    import ipfx_pkg::*;
#(
    parameter bit CODE32  = 1'b0,
    parameter int MAX_PFX = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         i_valid,
    input  logic [7:0]   i_byte,
    output logic         o_ready,
    output logic         o_done,
    output logic         o_err,
    output logic [2:0]   o_seg,
    output logic         o_osz32,
    output logic         o_asz32,
    output logic [1:0]   o_rep,
    output logic         o_esc,
    output logic         o_unk,
    output logic [7:0]   o_opc,
    output logic         o_has_modrm,
    output logic [7:0]   o_modrm,
    output logic         o_has_sib,
    output logic [7:0]   o_sib,
    output logic [2:0]   o_disp_len,
    output logic [31:0]  o_disp,
    output logic [2:0]   o_imm_len,
    output logic [31:0]  o_imm
);
    localparam int CW = $clog2(MAX_PFX + 1);
    localparam int BW = $clog2(FIELD_BY);

    function automatic rec_t rec_blank();
        rec_t r;
        r     = '0;
        r.osz = CODE32;
        r.asz = CODE32;
        return r;
    endfunction

    st_e            st, st_n;
    rec_t           w, nw, q;
    logic [CW-1:0]  npfx, np_n;
    logic [BW-1:0]  bcnt, bc_n;
    logic           rdy, done_q, fin, acc;

    logic           pd_is;
    pcls_e          pd_cls;
    seg_e           pd_seg;
    rep_e           pd_rep;
    logic           od_m, od_unk;
    immk_e          od_imm;
    logic           ea_sib;
    logic [LEN_W-1:0] ea_dlen, ilen_of;

    ipfx_pfx_dec u_pfx (
        .i_b   (i_byte),
        .o_is  (pd_is),
        .o_cls (pd_cls),
        .o_seg (pd_seg),
        .o_rep (pd_rep)
    );

    ipfx_op_dec u_op (
        .i_b     (i_byte),
        .o_has_m (od_m),
        .o_imm   (od_imm),
        .o_unk   (od_unk)
    );

    ipfx_ea_len u_ea (
        .i_mod   (i_byte[7:6]),
        .i_rm    (i_byte[2:0]),
        .i_asz32 (w.asz),
        .o_sib   (ea_sib),
        .o_dlen  (ea_dlen)
    );

    assign acc = i_valid & rdy;

    always_comb begin
        unique case (od_imm)
            IMM_BYTE: ilen_of = LEN_W'(1);
            IMM_FULL: ilen_of = w.osz ? LEN_W'(4) : LEN_W'(2);
            default:  ilen_of = '0;
        endcase
    end

    // next-state and working-record logic
    always_comb begin
        st_n = st;
        nw   = w;
        np_n = npfx;
        bc_n = bcnt;
        fin  = 1'b0;
        if (acc) begin
            unique case (st)
                ST_PFX: begin
                    if (pd_is) begin
                        if (npfx == CW'(MAX_PFX)) begin
                            nw.err = 1'b1;
                            fin    = 1'b1;
                        end else begin
                            np_n = npfx + 1'b1;
                            unique case (pd_cls)
                                PC_SEG: nw.seg = pd_seg;
                                PC_ASZ: nw.asz = ~CODE32;
                                PC_OSZ: nw.osz = ~CODE32;
                                PC_REP: nw.rep = pd_rep;
                            endcase
                        end
                    end else if (i_byte == ESC_BYTE) begin
                        nw.esc = 1'b1;
                        st_n   = ST_ESC;
                    end else begin
                        nw.opc  = i_byte;
                        nw.unk  = od_unk;
                        nw.ilen = ilen_of;
                        bc_n    = '0;
                        if (od_m) begin
                            st_n = ST_MODRM;
                        end else if (ilen_of != '0) begin
                            st_n = ST_IMM;
                        end else begin
                            fin = 1'b1;
                        end
                    end
                end
                ST_ESC: begin
                    nw.opc = i_byte;
                    fin    = 1'b1;
                end
                ST_MODRM: begin
                    nw.has_m = 1'b1;
                    nw.modrm = i_byte;
                    nw.dlen  = ea_dlen;
                    bc_n     = '0;
                    if (ea_sib) begin
                        st_n = ST_SIB;
                    end else if (ea_dlen != '0) begin
                        st_n = ST_DISP;
                    end else if (w.ilen != '0) begin
                        st_n = ST_IMM;
                    end else begin
                        fin = 1'b1;
                    end
                end
                ST_SIB: begin
                    nw.has_s = 1'b1;
                    nw.sib   = i_byte;
                    if (w.modrm[7:6] == 2'd0 && i_byte[2:0] == 3'd5) begin
                        nw.dlen = LEN_W'(4);
                    end
                    if (nw.dlen != '0) begin
                        st_n = ST_DISP;
                    end else if (w.ilen != '0) begin
                        st_n = ST_IMM;
                    end else begin
                        fin = 1'b1;
                    end
                end
                ST_DISP: begin
                    nw.disp[{bcnt, 3'b000} +: BYTE_W] = i_byte;
                    bc_n = bcnt + 1'b1;
                    if ((LEN_W'(bcnt) + LEN_W'(1)) == w.dlen) begin
                        bc_n = '0;
                        if (w.ilen != '0) begin
                            st_n = ST_IMM;
                        end else begin
                            fin = 1'b1;
                        end
                    end
                end
                ST_IMM: begin
                    nw.imm[{bcnt, 3'b000} +: BYTE_W] = i_byte;
                    bc_n = bcnt + 1'b1;
                    if ((LEN_W'(bcnt) + LEN_W'(1)) == w.ilen) begin
                        bc_n = '0;
                        fin  = 1'b1;
                    end
                end
                default: st_n = ST_PFX;
            endcase
        end
        if (fin) begin
            st_n = ST_PFX;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_PFX;
            bcnt <= '0;
            npfx <= '0;
            w    <= rec_blank();
        end else begin
            st   <= st_n;
            bcnt <= bc_n;
            if (fin) begin
                npfx <= '0;
                w    <= rec_blank();
            end else begin
                npfx <= np_n;
                w    <= nw;
            end
        end
    end

    // published record and handshake outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy    <= 1'b0;
            done_q <= 1'b0;
            q      <= '0;
        end else begin
            rdy    <= 1'b1;
            done_q <= fin;
            if (fin) begin
                q <= nw;
            end
        end
    end

    assign o_ready     = rdy;
    assign o_done      = done_q;
    assign o_err       = q.err;
    assign o_seg       = q.seg;
    assign o_osz32     = q.osz;
    assign o_asz32     = q.asz;
    assign o_rep       = q.rep;
    assign o_esc       = q.esc;
    assign o_unk       = q.unk;
    assign o_opc       = q.opc;
    assign o_has_modrm = q.has_m;
    assign o_modrm     = q.modrm;
    assign o_has_sib   = q.has_s;
    assign o_sib       = q.sib;
    assign o_disp_len  = q.dlen;
    assign o_disp      = q.disp;
    assign o_imm_len   = q.ilen;
    assign o_imm       = q.imm;

    p_ready_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> rdy);

    p_pfx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        npfx <= CW'(MAX_PFX));

    p_err_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (o_done && o_err) |-> (!o_has_modrm && o_disp_len == 3'd0 && o_imm_len == 3'd0 && o_opc == 8'h00));

    p_disp16_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (o_done && !o_asz32) |-> (o_disp_len <= 3'd2 && !o_has_sib));

    p_sib_form_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_done && o_has_sib) |-> (o_asz32 && o_modrm[2:0] == 3'd4 && o_modrm[7:6] != 2'd3));

    p_imm_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (o_done && o_imm_len == 3'd4) |-> o_osz32);

    p_done_after_acc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        o_done |-> $past(acc));

    p_record_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(q));

endmodule

// File: tb/ipfx_parser_test.sv
`timescale 1ns/1ps
module ipfx_parser_test;
    import ipfx_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_valid = 1'b0;
    logic [7:0]  i_byte = 8'h00;
    logic        o_ready, o_done, o_err, o_osz32, o_asz32, o_esc, o_unk;
    logic        o_has_modrm, o_has_sib;
    logic [2:0]  o_seg, o_disp_len, o_imm_len;
    logic [1:0]  o_rep;
    logic [7:0]  o_opc, o_modrm, o_sib;
    logic [31:0] o_disp, o_imm;

    int tests = 0;
    int fails = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    ipfx_parser uut (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_byte(i_byte),
        .o_ready(o_ready), .o_done(o_done), .o_err(o_err), .o_seg(o_seg),
        .o_osz32(o_osz32), .o_asz32(o_asz32), .o_rep(o_rep), .o_esc(o_esc),
        .o_unk(o_unk), .o_opc(o_opc), .o_has_modrm(o_has_modrm),
        .o_modrm(o_modrm), .o_has_sib(o_has_sib), .o_sib(o_sib),
        .o_disp_len(o_disp_len), .o_disp(o_disp), .o_imm_len(o_imm_len),
        .o_imm(o_imm)
    );

    logic [7:0] strm [0:4159];
    int         n = 0;
    rec_t       expr [0:4095];
    int         eend [0:4095];
    int         nrec = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        strm[n] = b;
        n++;
    endtask

    function automatic bit is_pfx(input logic [7:0] b);
        return (b == 8'h26 || b == 8'h2E || b == 8'h36 || b == 8'h3E ||
                b == 8'h64 || b == 8'h65 || b == 8'h66 || b == 8'h67 ||
                b == 8'hF2 || b == 8'hF3);
    endfunction

    // returns {unknown, has_modrm, imm kind(0 none,1 byte,2 full)}
    function automatic logic [3:0] op_kind(input logic [7:0] b);
        int lo;
        lo = int'(b[2:0]);
        if (b < 8'h40) begin
            if (lo < 4)  return 4'b0100;
            if (lo == 4) return 4'b0001;
            if (lo == 5) return 4'b0010;
            return 4'b1000;
        end
        if (b >= 8'h88 && b <= 8'h8B) return 4'b0100;
        if (b == 8'h80 || b == 8'h83 || b == 8'hC6) return 4'b0101;
        if (b == 8'h81 || b == 8'hC7) return 4'b0110;
        if ((b >= 8'h90 && b <= 8'h97) || b == 8'hC3) return 4'b0000;
        if (b >= 8'hB0 && b <= 8'hB7) return 4'b0001;
        if (b >= 8'hB8 && b <= 8'hBF) return 4'b0010;
        if (b == 8'hE8 || b == 8'hE9) return 4'b0010;
        if (b == 8'hEB) return 4'b0001;
        return 4'b1000;
    endfunction

    task automatic model_all();
        int i;
        i = 0;
        nrec = 0;
        while (i < n) begin
            rec_t r;
            int np;
            bit stop;
            logic [7:0] b;
            logic [3:0] k;
            logic [1:0] md;
            logic [2:0] rm;
            r = '0;
            np = 0;
            stop = 0;
            while (is_pfx(strm[i]) && !stop) begin
                b = strm[i];
                i++;
                if (np == 14) begin
                    r.err = 1'b1;
                    stop = 1;
                end else begin
                    np++;
                    case (b)
                        8'h26: r.seg = SEG_ES;
                        8'h2E: r.seg = SEG_CS;
                        8'h36: r.seg = SEG_SS;
                        8'h3E: r.seg = SEG_DS;
                        8'h64: r.seg = SEG_FS;
                        8'h65: r.seg = SEG_GS;
                        8'h66: r.osz = 1'b1;
                        8'h67: r.asz = 1'b1;
                        8'hF2: r.rep = REP_NE;
                        default: r.rep = REP_EQ;
                    endcase
                end
            end
            if (!stop) begin
                b = strm[i];
                i++;
                if (b == 8'h0F) begin
                    r.esc = 1'b1;
                    r.opc = strm[i];
                    i++;
                end else begin
                    r.opc = b;
                    k = op_kind(b);
                    r.unk = k[3];
                    r.ilen = (k[1:0] == 2'd1) ? 3'd1 : (k[1:0] == 2'd2) ? (r.osz ? 3'd4 : 3'd2) : 3'd0;
                    if (k[2]) begin
                        r.has_m = 1'b1;
                        r.modrm = strm[i];
                        i++;
                        md = r.modrm[7:6];
                        rm = r.modrm[2:0];
                        if (md == 2'd1) r.dlen = 3'd1;
                        else if (md == 2'd2) r.dlen = r.asz ? 3'd4 : 3'd2;
                        else if (md == 2'd0 && r.asz && rm == 3'd5) r.dlen = 3'd4;
                        else if (md == 2'd0 && !r.asz && rm == 3'd6) r.dlen = 3'd2;
                        if (r.asz && md != 2'd3 && rm == 3'd4) begin
                            r.has_s = 1'b1;
                            r.sib = strm[i];
                            i++;
                            if (md == 2'd0 && r.sib[2:0] == 3'd5) r.dlen = 3'd4;
                        end
                    end
                    for (int j = 0; j < int'(r.dlen); j++) begin
                        r.disp[8*j +: 8] = strm[i];
                        i++;
                    end
                    for (int j = 0; j < int'(r.ilen); j++) begin
                        r.imm[8*j +: 8] = strm[i];
                        i++;
                    end
                end
            end
            if (i - 1 < n) begin
                expr[nrec] = r;
                eend[nrec] = i - 1;
                nrec++;
            end
        end
    endtask

    task automatic cmp(input rec_t e);
        chk("R5 err",            32'(o_err), 32'(e.err));
        chk("R2 seg",            32'(o_seg), 32'(e.seg));
        chk("R3 osz",            32'(o_osz32), 32'(e.osz));
        chk("R3 asz",            32'(o_asz32), 32'(e.asz));
        chk("R4 rep",            32'(o_rep), 32'(e.rep));
        chk("R11 esc",           32'(o_esc), 32'(e.esc));
        chk("R13 unk",           32'(o_unk), 32'(e.unk));
        chk("R6 opcode",         32'(o_opc), 32'(e.opc));
        chk("R6 has_modrm",      32'(o_has_modrm), 32'(e.has_m));
        chk("R6 modrm",          32'(o_modrm), 32'(e.modrm));
        chk("R8 has_sib",        32'(o_has_sib), 32'(e.has_s));
        chk("R8 sib",            32'(o_sib), 32'(e.sib));
        chk("R7 disp_len",       32'(o_disp_len), 32'(e.dlen));
        chk("R10 disp",          o_disp, e.disp);
        chk("R9 imm_len",        32'(o_imm_len), 32'(e.ilen));
        chk("R10 imm",           o_imm, e.imm);
    endtask

    localparam logic [7:0] PFX_TAB [0:9] = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64,
                                             8'h65, 8'h66, 8'h67, 8'hF2, 8'hF3};
    localparam logic [7:0] OPC_TAB [0:15] = '{8'h8B, 8'h89, 8'h03, 8'h04, 8'h05, 8'h80,
                                              8'h81, 8'h83, 8'h90, 8'hB3, 8'hBA, 8'hC6,
                                              8'hC7, 8'hE8, 8'hEB, 8'h0F};

    task automatic build();
        // R2 segment overrides, last wins
        push(8'h26); push(8'h8B); push(8'h05);
        push(8'h2E); push(8'h3E); push(8'h90);
        push(8'h64); push(8'h90);
        push(8'h36); push(8'h90);
        // R3 either prefix order
        push(8'h65); push(8'h66); push(8'h8B); push(8'h05);
        push(8'h66); push(8'h65); push(8'h8B); push(8'h05);
        // R4 repeat kinds
        push(8'hF2); push(8'hF3); push(8'h90);
        push(8'hF3); push(8'hF2); push(8'hC3);
        // R8 32-bit addressing with SIB
        push(8'h67); push(8'h8B); push(8'h04); push(8'h24);
        push(8'h67); push(8'h8B); push(8'h04); push(8'h25);
        push(8'h78); push(8'h56); push(8'h34); push(8'h12);
        push(8'h67); push(8'h8B); push(8'h44); push(8'h10); push(8'h7F);
        push(8'h67); push(8'h8B); push(8'h85); push(8'h11); push(8'h22); push(8'h33); push(8'h44);
        push(8'h67); push(8'h8B); push(8'hC4);
        // R7 16-bit displacements
        push(8'h8B); push(8'h06); push(8'h34); push(8'h12);
        push(8'h8B); push(8'h47); push(8'h80);
        push(8'h8B); push(8'h87); push(8'hEF); push(8'hBE);
        push(8'h8B); push(8'hC1);
        // R9 immediates
        push(8'h66); push(8'hB8); push(8'h01); push(8'h02); push(8'h03); push(8'h04);
        push(8'hB8); push(8'hAA); push(8'hBB);
        push(8'h04); push(8'h5A);
        push(8'h66); push(8'h81); push(8'hC0); push(8'hDD); push(8'hCC); push(8'hBB); push(8'hAA);
        push(8'h83); push(8'hC0); push(8'h01);
        push(8'hC7); push(8'h06); push(8'h00); push(8'h10); push(8'h22); push(8'h11);
        // R11 escape, R13 unknown
        push(8'h0F); push(8'hA2);
        push(8'h66); push(8'h0F); push(8'hB6);
        push(8'hD6);
        // R5 overflow at the 15th prefix, then a fresh instruction
        for (int j = 0; j < 14; j++) push(8'h26);
        push(8'h65);
        push(8'h90);
        for (int j = 0; j < 14; j++) push(8'h2E);
        push(8'h90);
        // random part
        for (int j = 0; j < 2600; j++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 25)      push(PFX_TAB[$urandom % 10]);
            else if (r < 60) push(OPC_TAB[$urandom % 16]);
            else             push(8'($urandom));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int ri;
        void'($urandom(32'h1DEC0DE5));
        build();
        model_all();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready in reset", 32'(o_ready), 32'd0);
        chk("R1 done in reset",  32'(o_done), 32'd0);
        chk("R1 opcode in reset", 32'(o_opc), 32'd0);
        chk("R1 seg in reset",    32'(o_seg), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(o_ready), 32'd1);
        chk("R1 done after reset",  32'(o_done), 32'd0);
        ri = 0;
        for (int i = 0; i < n; i++) begin
            i_valid = 1'b1;
            i_byte  = strm[i];
            @(negedge clk);
            i_valid = 1'b0;
            i_byte  = 8'($urandom);
            if (ri < nrec && eend[ri] == i) begin
                chk("R12 done pulse", 32'(o_done), 32'd1);
                cmp(expr[ri]);
                ri++;
            end else if (o_done !== 1'b0) begin
                chk("R12 no early done", 32'(o_done), 32'd0);
            end
            if (($urandom % 4) == 0) begin
                int g;
                g = 1 + int'($urandom % 2);
                for (int k = 0; k < g; k++) begin
                    @(negedge clk);
                    if (o_done !== 1'b0) chk("R12 idle gap", 32'(o_done), 32'd0);
                end
            end
        end
        // R12: idle cycles neither pulse nor alter the record
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R12 idle done", 32'(o_done), 32'd0);
            chk("R12 hold opcode", 32'(o_opc), 32'(expr[nrec-1].opc));
        end
        chk("R12 records seen", 32'(ri), 32'(nrec));
        ended = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule